// File: doc/BRIEF.md
# Single-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer of 9-bit words that shares one clock for its write and read sides. Its depth is a parameter with a value from 256 to 8192. Software-visible threshold logic drives four active-low status outputs: empty, full, nearly-empty and nearly-full. Two 16-bit offsets, held in an internal offset store, set the nearly-empty and nearly-full thresholds.

The `wen2_ld` input has two possible roles. The level it holds while reset is active fixes that role until the next reset:
- **Two-enable role** (high at reset): it is a second write enable.
- **Load role** (low at reset): it is a strobe. While the strobe is low, write cycles load offset bytes and read cycles return them on the data output. The FIFO itself is left alone in those cycles.

The FIFO refuses writes when it is full and refuses reads when it is empty. After an unserved read the data output keeps the last word it delivered. An active-low output enable zeroes the visible data without disturbing the word that is held.

Top module: `fifo_pf`

## Requirements
- R1: While reset is held and after its release, `empty_n`=0, `full_n`=1, `almost_empty_n`=0, `almost_full_n`=1 and `dout`=0. The default offsets are 7 and 7. Internal reset is released two rising clocks after `rst_n` rises.
- R2: `wen2_ld` is sampled on every clock while internal reset is active. If it was high, the part is in two-enable role, and a FIFO write happens only when `wen1_n`=0 and `wen2_ld`=1 at a rising clock.
- R3: A write attempted while the fill count equals the depth changes neither the stored words nor the count.
- R4: A read attempted while the fill count is zero changes nothing, and `dout` keeps the last word read (zero if none since reset).
- R5: When `ren1_n`=0 and `ren2_n`=0 and the FIFO is not empty, the oldest word appears on `dout` after that clock edge, in write order.
- R6: `empty_n` is 0 exactly when the fill count is 0. `full_n` is 0 exactly when the fill count equals the depth.
- R7: `almost_empty_n` is 0 exactly when the fill count is less than or equal to the 16-bit nearly-empty offset.
- R8: `almost_full_n` is 0 exactly when (depth minus fill count) is less than or equal to the 16-bit nearly-full offset.
- R9: In load role, each clock with `wen2_ld`=0 and `wen1_n`=0 stores `din[7:0]` into the next offset byte. The cycling order is: empty-offset low byte, empty-offset high byte, full-offset low byte, full-offset high byte, then back to the first. No FIFO word is written in these cycles.
- R10: The offset-load position is kept when `wen2_ld` returns high, so the next load continues the sequence.
- R11: In load role, a clock with `wen2_ld`=0 and both read enables low places the next offset byte on `dout` as {0, byte}, using its own position in the same four-byte order. The FIFO read position does not move.
- R12: In load role with `wen2_ld`=1, `wen1_n`=0 alone writes a word into the FIFO.
- R13: `oe_n`=1 forces `dout` to 0. Returning `oe_n` to 0 shows the held word again.
- R14: A clock with both a write and a read served leaves the fill count unchanged and still delivers words in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the write and read sides |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wen1_n | input | 1 | Active-low write enable |
| wen2_ld | input | 1 | Second write enable or offset-load strobe, chosen at reset |
| ren1_n | input | 1 | Active-low read enable |
| ren2_n | input | 1 | Second active-low read enable |
| oe_n | input | 1 | Active-low output enable |
| din | input | 9 | Write data |
| dout | output | 9 | Read data, zero while disabled |
| empty_n | output | 1 | Low when empty |
| full_n | output | 1 | Low when full |
| almost_empty_n | output | 1 | Low at or below the nearly-empty threshold |
| almost_full_n | output | 1 | Low when free space is at or below the nearly-full threshold |

## Verification
The hardest case to reach from the ports is the full boundary. It needs exactly as many writes as the depth, and then a write that arrives together with a read, or alone against a full store. A deterministic fill of every slot, with flag checks at each level, brings the design to that edge. Long write-biased and read-biased pseudo-random phases then hover around both ends. In load role, the same random stream occasionally drops the strobe, so thresholds shift while the buffer is partly full.

// File: rtl/fifo_pf_pkg.sv
package fifo_pf_pkg;
  localparam int WORD_W = 9;
  localparam int OFS_W  = 16;
  localparam int BYTE_W = 8;
  localparam int NUM_OFS_BYTES = 4;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [OFS_W-1:0]  ofs_t;
  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic {
    ROLE_WEN2 = 1'b0,
    ROLE_LOAD = 1'b1
  } role_e;
endpackage

// File: rtl/fifo_pf_ptrs.sv
module fifo_pf_ptrs #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  output logic [AW-1:0] waddr,
  output logic [AW-1:0] raddr,
  output logic [CW-1:0] count
);
  logic [CW-1:0] wptr_q, wptr_d;
  logic [CW-1:0] rptr_q, rptr_d;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    if (wr_en) wptr_d = wptr_q + 1'b1;
    if (rd_en) rptr_d = rptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
    end
  end

  assign waddr = wptr_q[AW-1:0];
  assign raddr = rptr_q[AW-1:0];
  assign count = wptr_q - rptr_q;
endmodule

// File: rtl/fifo_pf_flags.sv
module fifo_pf_flags
  import fifo_pf_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic [CW-1:0] count,
  input  ofs_t          ae_ofs,
  input  ofs_t          af_ofs,
  output logic          empty_n,
  output logic          full_n,
  output logic          almost_empty_n,
  output logic          almost_full_n
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic [CW-1:0] free_cnt;
  ofs_t          fill_w;
  ofs_t          free_w;

  always_comb begin
    free_cnt       = DEPTH_C - count;
    fill_w         = ofs_t'(count);
    free_w         = ofs_t'(free_cnt);
    empty_n        = (count != '0);
    full_n         = (count != DEPTH_C);
    almost_empty_n = !(fill_w <= ae_ofs);
    almost_full_n  = !(free_w <= af_ofs);
  end
endmodule

// File: rtl/fifo_pf_ofs.sv
module fifo_pf_ofs
  import fifo_pf_pkg::*;
#(
  parameter int AE_DEFAULT = 7,
  parameter int AF_DEFAULT = 7,
  localparam int SW = $clog2(NUM_OFS_BYTES)
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  logic  rd_en,
  input  byte_t wbyte,
  output byte_t rbyte,
  output ofs_t  ae_ofs,
  output ofs_t  af_ofs
);
  logic [SW-1:0] wsel_q, wsel_d;
  logic [SW-1:0] rsel_q, rsel_d;
  byte_t         bytes_w [NUM_OFS_BYTES];

  for (genvar g = 0; g < NUM_OFS_BYTES; g++) begin : g_byte
    localparam ofs_t  DEF  = (g < 2) ? ofs_t'(AE_DEFAULT) : ofs_t'(AF_DEFAULT);
    localparam byte_t INIT = (g % 2 == 1) ? DEF[15:8] : DEF[7:0];
    byte_t q;
    logic  hit;

    assign hit = wr_en && (wsel_q == SW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= INIT;
      else if (hit) q <= wbyte;
    end

    assign bytes_w[g] = q;
  end

  always_comb begin
    wsel_d = wsel_q;
    rsel_d = rsel_q;
    if (wr_en) wsel_d = wsel_q + 1'b1;
    if (rd_en) rsel_d = rsel_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wsel_q <= '0;
      rsel_q <= '0;
    end else begin
      wsel_q <= wsel_d;
      rsel_q <= rsel_d;
    end
  end

  assign rbyte  = bytes_w[rsel_q];
  assign ae_ofs = {bytes_w[1], bytes_w[0]};
  assign af_ofs = {bytes_w[3], bytes_w[2]};
endmodule

// File: rtl/fifo_pf_ram.sv
module fifo_pf_ram
  import fifo_pf_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  word_t         wdata,
  input  logic [AW-1:0] raddr,
  output word_t         rdata
);
  word_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/fifo_pf.sv
module fifo_pf
  import fifo_pf_pkg::*;
#(
  parameter int DEPTH      = 256,
  parameter int AE_DEFAULT = 7,
  parameter int AF_DEFAULT = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wen1_n,
  input  logic       wen2_ld,
  input  logic       ren1_n,
  input  logic       ren2_n,
  input  logic       oe_n,
  input  logic [8:0] din,
  output logic [8:0] dout,
  output logic       empty_n,
  output logic       full_n,
  output logic       almost_empty_n,
  output logic       almost_full_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  // reset: asserted asynchronously, released after two clocks
  logic [1:0] rsync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  // role of the dual-purpose pin, loaded while reset is active
  role_e role_q, role_d;
  always_comb begin
    role_d = role_q;
    if (!rst_core_n) role_d = wen2_ld ? ROLE_WEN2 : ROLE_LOAD;
  end
  always_ff @(posedge clk) begin
    role_q <= role_d;
  end

  // request decode
  logic ld_active, wr_req, rd_req;
  logic fifo_wr, fifo_rd, ofs_wr, ofs_rd;

  assign ld_active = (role_q == ROLE_LOAD) && !wen2_ld;
  assign wr_req    = !wen1_n && wen2_ld;
  assign rd_req    = !ren1_n && !ren2_n;
  assign fifo_wr   = wr_req && full_n;
  assign fifo_rd   = rd_req && !ld_active && empty_n;
  assign ofs_wr    = ld_active && !wen1_n;
  assign ofs_rd    = ld_active && rd_req;

  // datapath
  logic [AW-1:0] waddr, raddr;
  logic [CW-1:0] count;
  word_t         rdata;
  byte_t         ofs_byte;
  ofs_t          ae_ofs, af_ofs;

  fifo_pf_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk   (clk),
    .rst_n (rst_core_n),
    .wr_en (fifo_wr),
    .rd_en (fifo_rd),
    .waddr (waddr),
    .raddr (raddr),
    .count (count)
  );

  fifo_pf_ram #(.DEPTH(DEPTH)) u_ram (
    .clk   (clk),
    .we    (fifo_wr),
    .waddr (waddr),
    .wdata (din),
    .raddr (raddr),
    .rdata (rdata)
  );

  fifo_pf_ofs #(.AE_DEFAULT(AE_DEFAULT), .AF_DEFAULT(AF_DEFAULT)) u_ofs (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .wr_en  (ofs_wr),
    .rd_en  (ofs_rd),
    .wbyte  (din[7:0]),
    .rbyte  (ofs_byte),
    .ae_ofs (ae_ofs),
    .af_ofs (af_ofs)
  );

  fifo_pf_flags #(.DEPTH(DEPTH)) u_flags (
    .count          (count),
    .ae_ofs         (ae_ofs),
    .af_ofs         (af_ofs),
    .empty_n        (empty_n),
    .full_n         (full_n),
    .almost_empty_n (almost_empty_n),
    .almost_full_n  (almost_full_n)
  );

  // output register: holds the last delivered word
  word_t dout_q, dout_d;
  always_comb begin
    dout_d = dout_q;
    if (fifo_rd)     dout_d = rdata;
    else if (ofs_rd) dout_d = {1'b0, ofs_byte};
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) dout_q <= '0;
    else             dout_q <= dout_d;
  end

  assign dout = oe_n ? '0 : dout_q;
endmodule

// File: rtl/fifo_pf_chk.sv
module fifo_pf_chk #(
  parameter int DEPTH = 256,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fifo_wr,
  input logic          fifo_rd,
  input logic          rd_req,
  input logic          ld_active,
  input logic [CW-1:0] count,
  input logic [8:0]    dout_q,
  input logic          empty_n,
  input logic          full_n
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (count == DEPTH_C) |-> !fifo_wr);

  p_underflow_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !ld_active && count == '0) |=> $stable(dout_q));

  p_flags_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(!empty_n && !full_n));

  p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    count <= DEPTH_C);

  p_load_leaves_fifo_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ld_active |=> $stable(count));

  p_rw_same_cycle_r14: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_wr && fifo_rd) |=> $stable(count));
endmodule

bind fifo_pf fifo_pf_chk #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .fifo_wr   (fifo_wr),
  .fifo_rd   (fifo_rd),
  .rd_req    (rd_req),
  .ld_active (ld_active),
  .count     (count),
  .dout_q    (dout_q),
  .empty_n   (empty_n),
  .full_n    (full_n)
);

// File: tb/sim_fifo_pf.sv
module sim_fifo_pf;
  localparam int DEPTH = 256;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wen1_n, wen2_ld, ren1_n, ren2_n, oe_n;
  logic [8:0] din;
  logic [8:0] dout;
  logic       empty_n, full_n, almost_empty_n, almost_full_n;

  always #5 clk = ~clk;

  fifo_pf #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .wen1_n(wen1_n), .wen2_ld(wen2_ld),
    .ren1_n(ren1_n), .ren2_n(ren2_n), .oe_n(oe_n), .din(din), .dout(dout),
    .empty_n(empty_n), .full_n(full_n), .almost_empty_n(almost_empty_n),
    .almost_full_n(almost_full_n)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model
  int          cnt, head, tail;
  logic [8:0]  mq [DEPTH];
  logic [8:0]  last;
  logic [7:0]  ob [4];
  int          wsel, rsel;
  bit          load_role;
  bit          oe_off;
  logic [15:0] lfsr;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    int aeo, afo;
    logic [8:0] exp_d;
    aeo   = {ob[1], ob[0]};
    afo   = {ob[3], ob[2]};
    exp_d = oe_off ? 9'd0 : last;
    chk(dout === exp_d, tag, dout, exp_d);
    chk(empty_n === (cnt != 0), "R6 empty", empty_n, cnt != 0);
    chk(full_n === (cnt != DEPTH), "R6 full", full_n, cnt != DEPTH);
    chk(almost_empty_n === !(cnt <= aeo), "R7 almost-empty", almost_empty_n, !(cnt <= aeo));
    chk(almost_full_n === !((DEPTH - cnt) <= afo), "R8 almost-full", almost_full_n,
        !((DEPTH - cnt) <= afo));
  endtask

  // one clock: drive at negedge, model, sample at following negedge
  task automatic step(input logic w1n, input logic w2, input logic r1n, input logic r2n,
                      input logic oen, input logic [8:0] d, input string tag);
    bit ldact, wr, rd;
    wen1_n = w1n; wen2_ld = w2; ren1_n = r1n; ren2_n = r2n; oe_n = oen; din = d;
    ldact = load_role && !w2;
    wr    = !w1n && w2;
    rd    = !r1n && !r2n;
    if (ldact) begin
      if (rd) begin
        last = {1'b0, ob[rsel]};
        rsel = (rsel + 1) % 4;
      end
      if (!w1n) begin
        ob[wsel] = d[7:0];
        wsel = (wsel + 1) % 4;
      end
    end else begin
      bit rd_ok, wr_ok;
      rd_ok = rd && (cnt > 0);
      wr_ok = wr && (cnt < DEPTH);
      if (rd_ok) begin
        last = mq[head];
        head = (head + 1) % DEPTH;
        cnt--;
      end
      if (wr_ok) begin
        mq[tail] = d;
        tail = (tail + 1) % DEPTH;
        cnt++;
      end
    end
    oe_off = oen;
    @(posedge clk);
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic do_reset(input logic role_lvl);
    @(negedge clk);
    rst_n = 1'b0; wen1_n = 1'b1; wen2_ld = role_lvl; ren1_n = 1'b1; ren2_n = 1'b1;
    oe_n = 1'b0; din = '0;
    cnt = 0; head = 0; tail = 0; last = '0; wsel = 0; rsel = 0; oe_off = 0;
    ob[0] = 8'd7; ob[1] = 8'd0; ob[2] = 8'd7; ob[3] = 8'd0;
    load_role = !role_lvl;
    repeat (3) @(negedge clk);
    check_all("R1 reset held");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    wen2_ld = 1'b1;
    check_all("R1 after release");
  endtask

  task automatic next_rand();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    lfsr = 16'hACE1;
    rst_n = 1'b1;

    // ---- two-enable role ----
    do_reset(1'b1);

    // R2: WEN2 low blocks the write
    step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 9'h155, "R2 wen2 low blocks write");
    // R4: read on empty holds zero
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 9'h000, "R4 read empty after reset");

    // fill every slot, then one extra (R3)
    for (int i = 0; i < DEPTH; i++)
      step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 9'((i * 37 + 5) & 511), "R2 write fill");
    step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 9'h1FF, "R3 write while full");
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 9'h1FE, "R5 one read enable only");

    // drain every word in order
    for (int i = 0; i < DEPTH; i++)
      step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 9'h000, "R5 read order");
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 9'h000, "R4 read empty holds last");
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 9'h000, "R4 second empty read");
    step(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 9'h000, "R13 output disabled");
    step(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 9'h000, "R13 output re-enabled");

    // simultaneous read and write (R14), including at empty
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 9'h0AA, "R14 rw at empty");
    for (int i = 0; i < 4; i++)
      step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 9'(i + 9'h40), "R14 prefill");
    for (int i = 0; i < 20; i++)
      step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 9'(i * 13 + 3), "R14 rw stream");

    // biased random sweep
    for (int ph = 0; ph < 4; ph++) begin
      for (int i = 0; i < 800; i++) begin
        logic w1n, r1n;
        next_rand();
        w1n = (ph % 2 == 0) ? (lfsr[0] & lfsr[1]) : (lfsr[0] | lfsr[1]);
        r1n = (ph % 2 == 0) ? (lfsr[2] | lfsr[3]) : (lfsr[2] & lfsr[3]);
        step(w1n, 1'b1, r1n, lfsr[4] & lfsr[5] & lfsr[6], lfsr[7:6] == 2'b11,
             lfsr[15:7], "R5 random two-enable");
      end
    end

    // ---- load role ----
    do_reset(1'b0);
    step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 9'd20, "R9 load empty-offset low");
    step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 9'h100, "R9 load empty-offset high");
    step(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 9'h000, "R10 strobe released");
    step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 9'd30, "R10 load resumes full-offset low");
    step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 9'd0, "R9 load full-offset high");
    for (int i = 0; i < 4; i++)
      step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 9'h000, "R11 offset readback");

    for (int i = 0; i < DEPTH + 1; i++)
      step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 9'((i * 11 + 1) & 511), "R12 single-enable fill");
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 9'h000, "R11 readback while full");
    for (int i = 0; i < DEPTH; i++)
      step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 9'h000, "R11 drain after readback");

    for (int i = 0; i < 1200; i++) begin
      logic w2;
      next_rand();
      w2 = !(lfsr[0] & lfsr[1] & lfsr[2]);
      step(lfsr[3] & (i % 400 > 200), w2, lfsr[4] | (i % 400 < 200), lfsr[5] & lfsr[6],
           lfsr[8:7] == 2'b11, lfsr[15:7], "R12 random load role");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule